// File: doc/BRIEF.md
# Chained Vector Multiply-Add Pipeline

This block computes `dst[k] = a[k] * b[k] + c[k]` over up to 64 integer lanes of 32 bits. The work is split into two dependent vector operations: a fully pipelined multiplier with a 7-cycle start-up, followed by a fully pipelined adder with a 6-cycle start-up. Both units accept one element per clock.

In chained mode, each product goes into the adder in the cycle it leaves the multiplier. In unchained mode, the products are parked in a buffer. The add phase starts only after the last product has been produced.

A per-lane write mask decides which destination lanes take the new result. Lanes whose mask bit is clear keep their old contents. On completion the block reports a done pulse and the total cycle count of the run, so software or a bench can compare the two scheduling modes directly.

Top module: `vma_chain_top`

## Requirements
- R1: For each lane k below the effective length whose mask bit is 1, the destination lane becomes `(a[k]*b[k] + c[k])` truncated to 32 bits (wrap on overflow). Lane k occupies bits `[32k+31:32k]` of the flattened vectors.
- R2: A lane whose mask bit (bit k of `mask_i`) is 0 keeps its previous destination value. The destination never changes while the block is idle.
- R3: With `chain_i`=1 at start, `done_o` is seen in the cycle after the (VL+12)th rising edge following the start edge, and `cycles_o` reads VL+13 (77 for VL=64).
- R4: With `chain_i`=0 at start, `done_o` follows after 2*VL+12 edges, and `cycles_o` reads 2*VL+13 (141 for VL=64). `cycles_o` holds that value until the next start.
- R5: The effective length is `vl_i` when 1..64. The values 0 and 65..127 select 64. Lanes at or above the effective length are not written.
- R6: `chain_i`, `vl_i` and `mask_i` are sampled only at the accepted start. Changing them during a run does not alter its results or timing.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The run in progress keeps its timing and results.
- R8: After reset, `busy_o`, `done_o`, `cycles_o` and every destination lane are zero.
- R9: `done_o` is a single-cycle pulse, and `busy_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run when idle |
| chain_i | input | 1 | 1 = forward products element by element |
| vl_i | input | 7 | Requested vector length |
| mask_i | input | 64 | Per-lane write enable |
| a_i | input | 2048 | Multiplicand lanes |
| b_i | input | 2048 | Multiplier lanes |
| c_i | input | 2048 | Addend lanes |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last result written this cycle |
| cycles_o | output | 8 | Cycle count of the current or last run |
| dst_o | output | 2048 | Destination lanes |

## Verification
The operand vectors are not captured at start. They are read lane by lane at issue, so the checks assume `a_i`, `b_i` and `c_i` stay constant from the accepted start until `done_o`. The stimulus loads fresh operands only while the block is idle and holds them for the whole run.

The control inputs carry no such assumption. The checker captures mode, length and mask itself at the accepted start, and the stimulus deliberately toggles those inputs and `start_i` mid-run. The bench sweeps every length in both modes, plus the out-of-range length codes.

// File: rtl/vma_pkg.sv
package vma_pkg;
  localparam int unsigned MUL_LAT_DEF = 7;
  localparam int unsigned ADD_LAT_DEF = 6;
endpackage

// File: rtl/vma_pipe.sv
// Fixed-latency valid/index/data delay line; one element per clock.
module vma_pipe #(
  parameter int unsigned DEPTH = 1,
  parameter int unsigned IW    = 6,
  parameter int unsigned W     = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [IW-1:0] idx_i,
  input  logic [W-1:0]  dat_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  dat_o
);
  logic [DEPTH-1:0] vld_q;
  logic [IW-1:0]    idx_q [DEPTH];
  logic [W-1:0]     dat_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_st
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) vld_q[0] <= 1'b0;
        else         vld_q[0] <= vld_i;
      always_ff @(posedge clk_i) begin
        idx_q[0] <= idx_i;
        dat_q[0] <= dat_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) vld_q[k] <= 1'b0;
        else         vld_q[k] <= vld_q[k-1];
      always_ff @(posedge clk_i) begin
        idx_q[k] <= idx_q[k-1];
        dat_q[k] <= dat_q[k-1];
      end
    end
  end

  assign vld_o = vld_q[DEPTH-1];
  assign idx_o = idx_q[DEPTH-1];
  assign dat_o = dat_q[DEPTH-1];
endmodule

// File: rtl/vma_ctrl.sv
// Run control: start capture, cycle counter, done pulse.
module vma_ctrl #(
  parameter int unsigned ELEMS = 64,
  parameter int unsigned VLW   = 7,
  parameter int unsigned CW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             chain_i,
  input  logic [VLW-1:0]   vl_i,
  input  logic [ELEMS-1:0] mask_i,
  input  logic             last_wr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CW-1:0]    cyc_o,
  output logic [VLW-1:0]   vl_o,
  output logic             chain_o,
  output logic [ELEMS-1:0] mask_o
);
  logic [VLW-1:0] vl_eff;
  assign vl_eff = (vl_i == '0 || vl_i > VLW'(ELEMS)) ? VLW'(ELEMS) : vl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      cyc_o   <= '0;
      vl_o    <= '0;
      chain_o <= 1'b0;
      mask_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o  <= 1'b1;
          cyc_o   <= CW'(1);
          vl_o    <= vl_eff;
          chain_o <= chain_i;
          mask_o  <= mask_i;
        end
      end else begin
        cyc_o <= cyc_o + CW'(1);
        if (last_wr_i) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vma_chain_top.sv
module vma_chain_top import vma_pkg::*; #(
  parameter int unsigned ELEMS   = 64,
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned MUL_LAT = MUL_LAT_DEF,
  parameter int unsigned ADD_LAT = ADD_LAT_DEF,
  localparam int unsigned IW  = $clog2(ELEMS),
  localparam int unsigned VLW = $clog2(ELEMS + 1),
  localparam int unsigned CW  = $clog2(2 * ELEMS + MUL_LAT + ADD_LAT + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   chain_i,
  input  logic [VLW-1:0]         vl_i,
  input  logic [ELEMS-1:0]       mask_i,
  input  logic [ELEMS*WIDTH-1:0] a_i,
  input  logic [ELEMS*WIDTH-1:0] b_i,
  input  logic [ELEMS*WIDTH-1:0] c_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [CW-1:0]          cycles_o,
  output logic [ELEMS*WIDTH-1:0] dst_o
);
  localparam logic [CW-1:0] BUF_OFS = CW'(MUL_LAT + 1);

  logic             busy_q, chain_q, last_wr;
  logic [CW-1:0]    cyc_q, vl_c;
  logic [VLW-1:0]   vl_q;
  logic [ELEMS-1:0] mask_q;

  vma_ctrl #(.ELEMS(ELEMS), .VLW(VLW), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .chain_i, .vl_i, .mask_i,
    .last_wr_i(last_wr), .busy_o(busy_q), .done_o, .cyc_o(cyc_q),
    .vl_o(vl_q), .chain_o(chain_q), .mask_o(mask_q)
  );

  assign vl_c = CW'(vl_q);

  // Multiply issue: cycle n (1..VL) carries lane n-1.
  logic             mul_go;
  logic [IW-1:0]    mul_idx;
  logic [WIDTH-1:0] mul_prod;
  assign mul_go   = busy_q && cyc_q >= CW'(1) && cyc_q <= vl_c;
  assign mul_idx  = IW'(cyc_q - CW'(1));
  assign mul_prod = a_i[mul_idx*WIDTH +: WIDTH] * b_i[mul_idx*WIDTH +: WIDTH];

  logic             mo_vld;
  logic [IW-1:0]    mo_idx;
  logic [WIDTH-1:0] mo_dat;

  vma_pipe #(.DEPTH(MUL_LAT), .IW(IW), .W(WIDTH)) u_mul (
    .clk_i, .rst_ni, .vld_i(mul_go), .idx_i(mul_idx), .dat_i(mul_prod),
    .vld_o(mo_vld), .idx_o(mo_idx), .dat_o(mo_dat)
  );

  // Product buffer for the unchained schedule.
  logic [WIDTH-1:0] pbuf [ELEMS];
  always_ff @(posedge clk_i)
    if (mo_vld && !chain_q) pbuf[mo_idx] <= mo_dat;

  // Unchained add issue starts one cycle after the last product is parked.
  logic          ub_go;
  logic [IW-1:0] ub_idx;
  assign ub_go  = busy_q && !chain_q && cyc_q >= vl_c + BUF_OFS
                  && cyc_q < vl_c + vl_c + BUF_OFS;
  assign ub_idx = IW'(cyc_q - vl_c - BUF_OFS);

  logic             ai_vld;
  logic [IW-1:0]    ai_idx;
  logic [WIDTH-1:0] ai_prod, ai_sum;
  assign ai_vld  = chain_q ? mo_vld : ub_go;
  assign ai_idx  = chain_q ? mo_idx : ub_idx;
  assign ai_prod = chain_q ? mo_dat : pbuf[ub_idx];
  assign ai_sum  = ai_prod + c_i[ai_idx*WIDTH +: WIDTH];

  logic             ao_vld;
  logic [IW-1:0]    ao_idx;
  logic [WIDTH-1:0] ao_dat;

  // Last adder stage is the destination write itself.
  vma_pipe #(.DEPTH(ADD_LAT - 1), .IW(IW), .W(WIDTH)) u_add (
    .clk_i, .rst_ni, .vld_i(ai_vld), .idx_i(ai_idx), .dat_i(ai_sum),
    .vld_o(ao_vld), .idx_o(ao_idx), .dat_o(ao_dat)
  );

  assign last_wr = ao_vld && ao_idx == IW'(vl_q - VLW'(1));

  logic [ELEMS*WIDTH-1:0] dst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     dst_q <= '0;
    else if (ao_vld && mask_q[ao_idx]) dst_q[ao_idx*WIDTH +: WIDTH] <= ao_dat;
  end

  assign busy_o   = busy_q;
  assign cycles_o = cyc_q;
  assign dst_o    = dst_q;
endmodule

// File: rtl/vma_chk.sv
module vma_chk #(
  parameter int unsigned ELEMS   = 64,
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned MUL_LAT = 7,
  parameter int unsigned ADD_LAT = 6,
  localparam int unsigned VLW = $clog2(ELEMS + 1),
  localparam int unsigned CW  = $clog2(2 * ELEMS + MUL_LAT + ADD_LAT + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic                   chain_i,
  input logic [VLW-1:0]         vl_i,
  input logic [ELEMS-1:0]       mask_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic [CW-1:0]          cycles_o,
  input logic [ELEMS*WIDTH-1:0] dst_o
);
  logic             c_q;
  logic [VLW-1:0]   v_q;
  logic [ELEMS-1:0] m_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q <= 1'b0;
      v_q <= '0;
      m_q <= '0;
    end else if (start_i && !busy_o) begin
      c_q <= chain_i;
      v_q <= (vl_i == '0 || vl_i > VLW'(ELEMS)) ? VLW'(ELEMS) : vl_i;
      m_q <= mask_i;
    end
  end

  p_chain_cycles_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && c_q |-> cycles_o == CW'(v_q) + CW'(MUL_LAT + ADD_LAT));

  p_plain_cycles_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !c_q |-> cycles_o == CW'(v_q) + CW'(v_q) + CW'(MUL_LAT + ADD_LAT));

  p_count_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(cycles_o));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(dst_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  for (genvar k = 0; k < ELEMS; k++) begin : g_lane
    p_lane_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && (!m_q[k] || k >= int'(v_q)) |=> $stable(dst_o[k*WIDTH +: WIDTH]));
  end
endmodule

bind vma_chain_top vma_chk #(
  .ELEMS(ELEMS), .WIDTH(WIDTH), .MUL_LAT(MUL_LAT), .ADD_LAT(ADD_LAT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .chain_i(chain_i),
  .vl_i(vl_i), .mask_i(mask_i), .busy_o(busy_o), .done_o(done_o),
  .cycles_o(cycles_o), .dst_o(dst_o)
);

// File: tb/vma_chain_top_tb.sv
module vma_chain_top_tb;
  localparam int unsigned N = 64;
  localparam int unsigned W = 32;
  localparam int unsigned VLW = $clog2(N + 1);
  localparam int unsigned CW = $clog2(2 * N + 14);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, chain = 1'b0;
  logic [VLW-1:0] vl = '0;
  logic [N-1:0] mask = '0;
  logic [N*W-1:0] a = '0, b = '0, c = '0;
  logic busy, done;
  logic [CW-1:0] cycles;
  logic [N*W-1:0] dst;

  int total = 0, bad = 0;
  logic [W-1:0] exp_q [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  vma_chain_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chain_i(chain), .vl_i(vl),
    .mask_i(mask), .a_i(a), .b_i(b), .c_i(c), .busy_o(busy), .done_o(done),
    .cycles_o(cycles), .dst_o(dst)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  function automatic logic [W-1:0] opv(input int s, input int k, input int which);
    return W'(s * 32'h9E3779B1 + k * 32'h85EBCA77 + which * 32'hC2B2AE3D) ^ W'(k << which);
  endfunction

  // Runs one operation; disturb toggles controls mid-run (R6), restart pulses start (R7).
  task automatic run(input logic ch, input logic [VLW-1:0] vreq, input logic [N-1:0] m,
                     input int s, input bit disturb, input bit restart);
    int veff, n, elat;
    string tag;
    for (int k = 0; k < N; k++) begin
      a[k*W +: W] = opv(s, k, 1);
      b[k*W +: W] = opv(s, k, 2);
      c[k*W +: W] = opv(s, k, 3);
    end
    chain = ch; vl = vreq; mask = m; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R3 busy after start", 64'(busy), 64'd1);
    if (disturb) begin
      chain = ~ch; vl = vreq ^ VLW'(7'h15); mask = ~m;
    end
    veff = (vreq == 0 || vreq > N) ? N : int'(vreq);
    n = 1;
    while (!done && n < 400) begin
      if (restart) start = (n == 5);
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    n--;
    elat = (ch ? veff : 2 * veff) + 12;
    chk(ch ? "R3 latency" : "R4 latency", 64'(n), 64'(elat));
    chk(ch ? "R3 cycles" : "R4 cycles", 64'(cycles), 64'(elat + 1));
    chk("R9 busy low at done", 64'(busy), 64'd0);
    for (int k = 0; k < veff; k++)
      if (m[k]) exp_q[k] = opv(s, k, 1) * opv(s, k, 2) + opv(s, k, 3);
    for (int k = 0; k < N; k++) begin
      tag = (k >= veff) ? "R5 lane beyond length" : (m[k] ? "R1 lane result" : "R2 masked lane");
      chk(tag, 64'(dst[k*W +: W]), 64'(exp_q[k]));
    end
    @(negedge clk);
    chk("R9 done single pulse", 64'(done), 64'd0);
    chk("R4 cycles hold", 64'(cycles), 64'(elat + 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R3 act=expired exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) exp_q[k] = '0;
    repeat (3) @(negedge clk);
    chk("R8 busy reset", 64'(busy), 64'd0);
    chk("R8 done reset", 64'(done), 64'd0);
    chk("R8 cycles reset", 64'(cycles), 64'd0);
    for (int k = 0; k < N; k++) chk("R8 dst reset", 64'(dst[k*W +: W]), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(1'b1, 7'd64, '1, 1, 1'b0, 1'b0);   // R3: 77 cycles
    run(1'b0, 7'd64, '1, 2, 1'b0, 1'b0);   // R4: 141 cycles
    run(1'b1, 7'd64, '0, 3, 1'b0, 1'b0);   // R2: all lanes held
    for (int v = 1; v <= N; v++)
      for (int chv = 0; chv < 2; chv++)
        run(chv[0], VLW'(v), {N/32{32'(v * 32'h2545F491) ^ 32'(chv * 32'h0F0F0F0F)}},
            10 + 2 * v + chv, 1'b0, 1'b0);
    run(1'b1, 7'd0,   '1, 300, 1'b0, 1'b0);   // R5: 0 -> full length
    run(1'b0, 7'd65,  '1, 301, 1'b0, 1'b0);   // R5: over range -> full
    run(1'b1, 7'd127, 64'h5555_AAAA_0F0F_F0F0, 302, 1'b0, 1'b0);
    run(1'b0, 7'd20,  64'h0000_0000_00F3_A5C1, 303, 1'b1, 1'b0); // R6
    run(1'b1, 7'd33,  64'hFFFF_0000_FFFF_1234, 304, 1'b1, 1'b0); // R6
    run(1'b1, 7'd10,  '1, 305, 1'b0, 1'b1);   // R7
    run(1'b0, 7'd9,   '1, 306, 1'b0, 1'b1);   // R7

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule